// File: doc/BRIEF.md
# Configurable Asynchronous Serial Character Receiver

This block recovers characters from an asynchronous serial input line. A free-running enable pulse at sixteen times the bit rate paces all sampling. The line is first passed through a synchronizer. A falling edge is then qualified as a start bit by checking the line again half a bit later. After that, every data, parity and stop bit is sampled at its centre.

An 8-bit format word selects the character layout. Bits [1:0] give the data width, bit 3 enables parity, bit 4 selects even parity and bit 5 selects stick parity. The block latches the format word at the moment it detects a start edge.

Each character is delivered as a right-justified byte with a one-cycle valid strobe. Parity-error, framing-error and break flags are valid in the same cycle as the strobe. Word buffering, interrupt generation, rate division and any host register access belong to surrounding logic.

Top module: `serial_frame_rx`

## Requirements
- R1: While reset is asserted and after it is released, `rx_valid`, `rx_data`, `rx_par_err`, `rx_frm_err` and `rx_brk` are all 0, and no character is reported while the line stays idle at 1.
- R2: A falling edge of the synchronized line, seen on an oversample tick, starts reception only if the line is still 0 on the 8th tick after that edge. Otherwise the block returns to idle and reports nothing.
- R3: The data width is 5, 6, 7 or 8 bits for `fmt_cfg[1:0]` = 00, 01, 10 or 11. Data arrives least significant bit first and is presented right-justified, with the unused upper bits of `rx_data` equal to 0.
- R4: With `fmt_cfg[3]`=1 and `fmt_cfg[5]`=0, a parity bit is sampled after the last data bit. `rx_par_err` is set when the count of ones over data plus parity is even while `fmt_cfg[4]`=0, or odd while `fmt_cfg[4]`=1. With `fmt_cfg[3]`=0 no parity bit is expected and `rx_par_err` is 0.
- R5: With `fmt_cfg[3]`=1 and `fmt_cfg[5]`=1, the parity bit must equal the inverse of `fmt_cfg[4]`. Any other value sets `rx_par_err`.
- R6: Only the first stop bit is examined. A 0 there sets `rx_frm_err`. `fmt_cfg[2]`, the stop-count selection, has no effect on the flags or on the strobe timing.
- R7: When every data bit, the parity bit (if enabled) and the first stop bit are all 0, `rx_brk` is set together with `rx_frm_err`. The block then waits for the line to return to 1 before it accepts a new start edge.
- R8: `rx_valid` is a single-cycle pulse. It is asserted in the clock cycle after the tick that samples the middle of the first stop bit. `rx_data` and the three flags are valid in that cycle and change only when `rx_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| fmt_cfg | input | 8 | Character format word (bits [1:0], 3, 4, 5 used) |
| rx_data | output | 8 | Received character, right-justified |
| rx_valid | output | 1 | One-cycle strobe: a character is complete |
| rx_par_err | output | 1 | Parity mismatch for the reported character |
| rx_frm_err | output | 1 | First stop bit was 0 |
| rx_brk | output | 1 | Break: the whole character including stop was 0 |

## Verification
The bench drives each bit for exactly 16 ticks and changes the line just after a tick. The start edge is therefore seen on the tick after the change, numbered c0+1. The start bit is confirmed on tick c0+9. The stop bit with index s (counting the start bit as 0) is sampled on tick c0+9+16*s, and the strobe appears in the clock cycle after it.

The bench counts ticks at clock edges and captures the outputs on falling clock edges whenever the strobe is seen. Each character check therefore compares both the captured fields and the exact tick number of the strobe. It also confirms that exactly one strobe occurred per frame. For glitches and held breaks, it confirms that no strobe occurred during the quiet window before the next frame is sent.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int unsigned CHAR_W = 8;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4,
    S_BRKW  = 3'd5
  } rx_state_e;

  typedef struct packed {
    logic [1:0] wsel;
    logic       par_on;
    logic       par_even;
    logic       par_stick;
  } fmt_t;

  function automatic fmt_t decode_fmt(input logic [7:0] w);
    fmt_t f;
    f.wsel      = w[1:0];
    f.par_on    = w[3];
    f.par_even  = w[4];
    f.par_stick = w[5];
    return f;
  endfunction

  // Index of the final data bit: 4 for five-bit characters up to 7.
  function automatic logic [2:0] last_bit_idx(input logic [1:0] wsel);
    return 3'd4 + {1'b0, wsel};
  endfunction

  function automatic logic [CHAR_W-1:0] width_mask(input logic [1:0] wsel);
    logic [CHAR_W-1:0] m;
    for (int i = 0; i < CHAR_W; i++) begin
      m[i] = (i <= int'(last_bit_idx(wsel)));
    end
    return m;
  endfunction

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic stg_d;
    if (g == 0) begin : g_first
      assign stg_d = din;
    end else begin : g_next
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= 1'b1;
      else        stg_q[g] <= stg_d;
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/sfr_bit_timer.sv
module sfr_bit_timer #(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic mid_hit,
  output logic bit_hit
);

  localparam int unsigned CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_V  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_V = CW'(OSR - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = (cnt_q == LAST_V) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign mid_hit = tick & (cnt_q == MID_V);
  assign bit_hit = tick & (cnt_q == LAST_V);

  // R8: sampling instants only move on oversample ticks or restarts
  p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/sfr_frame_ctrl.sv
module sfr_frame_ctrl
  import sfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd_s,
  input  logic [7:0]        fmt_cfg,
  input  logic              mid_hit,
  input  logic              bit_hit,
  output logic              timer_clr,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_par_err,
  output logic              rx_frm_err,
  output logic              rx_brk
);

  rx_state_e         state_q, state_d;
  fmt_t              fmt_q, fmt_d;
  logic [2:0]        bidx_q, bidx_d;
  logic [CHAR_W-1:0] shf_q, shf_d;
  logic              zero_q, zero_d;
  logic              pbit_q, pbit_d;
  logic              last_q, last_d;

  logic [CHAR_W-1:0] dout_q, dout_d;
  logic              vld_q, vld_d;
  logic              perr_q, perr_d;
  logic              ferr_q, ferr_d;
  logic              brk_q, brk_d;

  logic              fall_edge;
  logic              par_bad;

  logic              unused_fmt;
  assign unused_fmt = ^{fmt_cfg[7:6], fmt_cfg[2]};

  assign fall_edge = tick & last_q & ~rxd_s;

  // Parity verdict from the captured data and parity bit.
  always_comb begin
    par_bad = 1'b0;
    if (fmt_q.par_on) begin
      if (fmt_q.par_stick) par_bad = (pbit_q == fmt_q.par_even);
      else                 par_bad = ((^shf_q ^ pbit_q) == fmt_q.par_even);
    end
  end

  always_comb begin
    state_d   = state_q;
    fmt_d     = fmt_q;
    bidx_d    = bidx_q;
    shf_d     = shf_q;
    zero_d    = zero_q;
    pbit_d    = pbit_q;
    last_d    = tick ? rxd_s : last_q;
    dout_d    = dout_q;
    vld_d     = 1'b0;
    perr_d    = perr_q;
    ferr_d    = ferr_q;
    brk_d     = brk_q;
    timer_clr = 1'b0;

    unique case (state_q)
      S_IDLE: begin
        if (fall_edge) begin
          state_d   = S_START;
          fmt_d     = decode_fmt(fmt_cfg);
          timer_clr = 1'b1;
        end
      end
      S_START: begin
        if (mid_hit) begin
          if (!rxd_s) begin
            state_d   = S_DATA;
            timer_clr = 1'b1;
            bidx_d    = '0;
            shf_d     = '0;
            zero_d    = 1'b1;
            pbit_d    = 1'b0;
          end else begin
            state_d = S_IDLE;
          end
        end
      end
      S_DATA: begin
        if (bit_hit) begin
          shf_d[bidx_q] = rxd_s;
          zero_d        = zero_q & ~rxd_s;
          if (bidx_q == last_bit_idx(fmt_q.wsel)) begin
            state_d = fmt_q.par_on ? S_PAR : S_STOP;
          end else begin
            bidx_d = bidx_q + 3'd1;
          end
        end
      end
      S_PAR: begin
        if (bit_hit) begin
          pbit_d  = rxd_s;
          zero_d  = zero_q & ~rxd_s;
          state_d = S_STOP;
        end
      end
      S_STOP: begin
        if (bit_hit) begin
          vld_d   = 1'b1;
          dout_d  = shf_q;
          perr_d  = par_bad;
          ferr_d  = ~rxd_s;
          brk_d   = zero_q & ~rxd_s;
          state_d = (zero_q & ~rxd_s) ? S_BRKW : S_IDLE;
        end
      end
      S_BRKW: begin
        if (tick && rxd_s) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      fmt_q   <= '0;
      bidx_q  <= '0;
      shf_q   <= '0;
      zero_q  <= 1'b0;
      pbit_q  <= 1'b0;
      last_q  <= 1'b1;
      dout_q  <= '0;
      vld_q   <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      fmt_q   <= fmt_d;
      bidx_q  <= bidx_d;
      shf_q   <= shf_d;
      zero_q  <= zero_d;
      pbit_q  <= pbit_d;
      last_q  <= last_d;
      dout_q  <= dout_d;
      vld_q   <= vld_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      brk_q   <= brk_d;
    end
  end

  assign rx_data    = dout_q;
  assign rx_valid   = vld_q;
  assign rx_par_err = perr_q;
  assign rx_frm_err = ferr_q;
  assign rx_brk     = brk_q;

  // R2: data phase is only entered from a start bit confirmed low
  p_start_confirm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DATA && $past(state_q) == S_START) |-> !$past(rxd_s));

  // R3: bits above the selected width are never reported
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data & ~width_mask(fmt_q.wsel)) == '0));

  // R7: a break always comes with a framing error and zero data
  p_break_frm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_brk) |-> (rx_frm_err && rx_data == '0));

  // R8: strobe lasts one cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R8: reported fields only move together with the strobe
  p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ({rx_data, rx_par_err, rx_frm_err, rx_brk} !=
     $past({rx_data, rx_par_err, rx_frm_err, rx_brk})) |-> rx_valid);

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import sfr_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic [7:0] fmt_cfg,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_par_err,
  output logic       rx_frm_err,
  output logic       rx_brk
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic rxd_s;
  logic mid_hit, bit_hit, timer_clr;

  sfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (rxd),
    .dout  (rxd_s)
  );

  sfr_bit_timer #(.OSR(OSR)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (os_tick),
    .clr     (timer_clr),
    .mid_hit (mid_hit),
    .bit_hit (bit_hit)
  );

  sfr_frame_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick       (os_tick),
    .rxd_s      (rxd_s),
    .fmt_cfg    (fmt_cfg),
    .mid_hit    (mid_hit),
    .bit_hit    (bit_hit),
    .timer_clr  (timer_clr),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_par_err (rx_par_err),
    .rx_frm_err (rx_frm_err),
    .rx_brk     (rx_brk)
  );

  // R1: nothing is reported while reset is being released
  p_quiet_reset_r1: assert property (@(posedge clk)
    !rst_int_n |=> !rx_valid);

endmodule

// File: tb/serial_frame_rx_bench.sv
module serial_frame_rx_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       os_tick;
  logic       rxd;
  logic [7:0] fmt_cfg;
  logic [7:0] rx_data;
  logic       rx_valid, rx_par_err, rx_frm_err, rx_brk;

  int tests_run  = 0;
  int tests_fail = 0;

  always #4 clk = ~clk;   // 125 MHz

  serial_frame_rx u_serial_frame_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .rxd        (rxd),
    .fmt_cfg    (fmt_cfg),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_par_err (rx_par_err),
    .rx_frm_err (rx_frm_err),
    .rx_brk     (rx_brk)
  );

  // Oversample tick: one cycle in four.
  int phase = 0;
  always @(negedge clk) begin
    phase   <= (phase == 3) ? 0 : phase + 1;
    os_tick <= (phase == 3);
  end

  int tcnt = 0;
  always @(posedge clk) if (os_tick === 1'b1) tcnt <= tcnt + 1;

  int         vcount = 0;
  int         cap_tick;
  logic [7:0] cap_data;
  logic       cap_par, cap_frm, cap_brk;
  always @(negedge clk) begin
    if (rx_valid === 1'b1) begin
      vcount   <= vcount + 1;
      cap_tick <= tcnt;
      cap_data <= rx_data;
      cap_par  <= rx_par_err;
      cap_frm  <= rx_frm_err;
      cap_brk  <= rx_brk;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      tests_fail = tests_fail + 1;
      $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
    end
  end

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    tests_run = tests_run + 1;
    if (act !== exp) begin
      tests_fail = tests_fail + 1;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (os_tick !== 1'b1);
    end
    @(negedge clk);
  endtask

  // Sends one character and checks the single strobe it must produce.
  task automatic run_frame(input string tag, input logic [7:0] cfg, input logic [7:0] d,
                           input bit flip_par, input bit stop0, input int hold_low);
    int          nb, n, s, v0, c0;
    bit          pen, pb, perr, brk;
    logic [7:0]  msk, dm;
    logic [15:0] fr;
    nb  = 5 + int'(cfg[1:0]);
    pen = cfg[3];
    msk = 8'hFF >> (8 - nb);
    dm  = d & msk;
    if (cfg[5]) pb = ~cfg[4];
    else        pb = cfg[4] ? ^dm : ~^dm;
    pb = pb ^ flip_par;
    if (!pen)        perr = 1'b0;
    else if (cfg[5]) perr = (pb != ~cfg[4]);
    else             perr = cfg[4] ? (^dm ^ pb) : ~(^dm ^ pb);
    brk = (dm == 8'h00) && !stop0 && (!pen || !pb);

    fr = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < nb; i++) fr[1+i] = dm[i];
    n = 1 + nb;
    if (pen) begin fr[n] = pb; n++; end
    s = n;
    fr[n] = stop0; n++;
    if (cfg[2]) begin fr[n] = 1'b1; n++; end

    fmt_cfg = cfg;
    v0 = vcount;
    wait_ticks(1);
    c0 = tcnt;
    for (int i = 0; i < n; i++) begin
      rxd = fr[i];
      wait_ticks(16);
    end
    if (hold_low > 0) begin
      rxd = 1'b0;
      wait_ticks(hold_low);
    end
    rxd = 1'b1;
    wait_ticks(20);

    check_eq(tag, "strobe count", vcount - v0, 1);
    check_eq(tag, "data", int'(cap_data), int'(dm));
    check_eq(tag, "parity error", int'(cap_par), int'(perr));
    check_eq(tag, "framing error", int'(cap_frm), int'(!stop0));
    check_eq(tag, "break", int'(cap_brk), int'(brk));
    check_eq("R8", "strobe tick", cap_tick - c0, 9 + 16 * s);
  endtask

  task automatic t_reset;
    check_eq("R1", "valid in reset", int'(rx_valid), 0);
    check_eq("R1", "data in reset", int'(rx_data), 0);
    check_eq("R1", "flags in reset", int'({rx_par_err, rx_frm_err, rx_brk}), 0);
    wait_ticks(40);
    check_eq("R1", "no strobe while idle", vcount, 0);
  endtask

  task automatic t_widths;   // R3: widths 5..8, upper bits zero
    run_frame("R3", 8'h00, 8'hFF, 0, 1, 0);
    run_frame("R3", 8'h01, 8'hAB, 0, 1, 0);
    run_frame("R3", 8'h02, 8'h55, 0, 1, 0);
    run_frame("R3", 8'h03, 8'hC3, 0, 1, 0);
  endtask

  task automatic t_parity;   // R4: odd and even, good and bad
    run_frame("R4", 8'h0B, 8'h35, 0, 1, 0);
    run_frame("R4", 8'h0B, 8'h35, 1, 1, 0);
    run_frame("R4", 8'h1B, 8'h96, 0, 1, 0);
    run_frame("R4", 8'h1A, 8'h6E, 1, 1, 0);
  endtask

  task automatic t_stick;    // R5: fixed parity level
    run_frame("R5", 8'h2B, 8'h0F, 0, 1, 0);
    run_frame("R5", 8'h2B, 8'h0F, 1, 1, 0);
    run_frame("R5", 8'h3B, 8'h0E, 0, 1, 0);
    run_frame("R5", 8'h3B, 8'h0E, 1, 1, 0);
  endtask

  task automatic t_stop;     // R6: only the first stop bit counts
    run_frame("R6", 8'h07, 8'h81, 0, 1, 0);
    run_frame("R6", 8'h07, 8'h5A, 0, 0, 0);
    run_frame("R6", 8'h03, 8'h5A, 0, 0, 0);
  endtask

  task automatic t_glitch;   // R2: short low pulse is rejected
    int v0;
    v0 = vcount;
    wait_ticks(1);
    rxd = 1'b0;
    wait_ticks(4);
    rxd = 1'b1;
    wait_ticks(40);
    check_eq("R2", "no strobe after glitch", vcount - v0, 0);
    run_frame("R2", 8'h03, 8'h3C, 0, 1, 0);
  endtask

  task automatic t_break;    // R7: break flagged, restart only after line high
    run_frame("R7", 8'h03, 8'h00, 0, 0, 60);
    run_frame("R7", 8'h0B, 8'h00, 1, 0, 30);
    run_frame("R7", 8'h03, 8'hA5, 0, 1, 0);
  endtask

  initial begin
    rst_n   = 1'b0;
    rxd     = 1'b1;
    fmt_cfg = 8'h03;
    os_tick = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_widths();
    t_parity();
    t_stick();
    t_stop();
    t_glitch();
    t_break();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
    $finish;
  end

endmodule